// File: doc/BRIEF.md
# Multi-phase voltage sag detector

This block watches signed voltage samples from several phases (two by default, phase A at index 0 and phase B at index 1). For each phase it counts the valid samples in an unbroken run whose magnitude is below a programmable threshold. It declares a sag on that phase once the run reaches a programmed length. The sag status of a phase stays up while the low samples continue. It drops as soon as a valid sample at or above the threshold arrives.

Each phase has its own disable bit, which removes that phase from detection. The detector combines the sag status of all phases into an interrupt line. When the interrupt is enabled, that line takes over a shared pulse output pin that otherwise carries an ordinary pulse signal. All configuration arrives on plain input ports.

Top module: `sag_monitor`

## Requirements
- R1: A valid sample counts as low when its absolute value, taken as a two's-complement number of SW bits, is strictly less than `mag_thr`. The most negative code has magnitude 2^(SW-1). A sample whose magnitude equals `mag_thr` is not low.
- R2: `sag[p]` rises in the cycle after the valid sample that brings the run of consecutive low samples on phase p to `run_len`.
- R3: A valid sample that is not low on an enabled phase clears that phase's run count. From the next cycle it also holds `sag[p]` at 0.
- R4: Cycles in which `smp_vld[p]` is 0 leave the run count and `sag[p]` of phase p unchanged.
- R5: The run count saturates at `run_len`, so `sag[p]` stays at 1 through any number of further low samples, including runs longer than 255. After a clearing sample, a full new run of `run_len` low samples is needed again.
- R6: A `run_len` of 0 acts as 1, so one low sample raises `sag[p]` in the next cycle.
- R7: `phase_off[p]` = 1 (bit 0 is phase A, bit 1 is phase B) holds the run count of phase p at 0. From the next cycle it also holds `sag[p]` at 0, whatever samples arrive.
- R8: `irq` is registered. In each cycle it equals `irq_en` AND the OR of `sag` over all phases, both as they were in the previous cycle.
- R9: `pulse_out` follows `irq` when `irq_en` is 1 and follows `pulse_in` when `irq_en` is 0, with no added delay.
- R10: While `rst_n` is low, `sag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | NPH | Per-phase sample strobe |
| smp | input | NPH*SW | Per-phase signed sample, phase p in slice p |
| mag_thr | input | SW | Unsigned magnitude threshold |
| run_len | input | 8 | Consecutive low samples needed for a sag |
| phase_off | input | NPH | Per-phase detection disable |
| irq_en | input | 1 | Routes the sag interrupt to the pulse pin |
| pulse_in | input | 1 | Normal pulse signal |
| sag | output | NPH | Per-phase sag status |
| irq | output | 1 | Registered sag interrupt |
| pulse_out | output | 1 | Shared pulse output pin |

## Verification
A sample presented before a clock edge affects `sag` in the cycle that follows that edge. The same holds for a phase disable or a threshold change. `irq` follows one cycle later again, two cycles after the sample, while `pulse_out` takes the value of `irq` or `pulse_in` in the same cycle. The bench drives its inputs just after each rising edge. A behavioural model advances at the same rising edges that the design uses, and every output is compared with that model at the falling edge. Each output is therefore checked in exactly the cycle it is due, never earlier or later.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int RUN_W = 8;

  // Run length actually used: a programmed zero acts as one.
  function automatic logic [RUN_W-1:0] eff_limit(input logic [RUN_W-1:0] cfg);
    return (cfg == '0) ? RUN_W'(1) : cfg;
  endfunction

  // Next run count, saturating at the limit.
  function automatic logic [RUN_W-1:0] run_step(input logic [RUN_W-1:0] cur,
                                                input logic [RUN_W-1:0] lim);
    return (cur >= lim) ? lim : cur + RUN_W'(1);
  endfunction

  // True when the run reaches the limit with this sample.
  function automatic logic run_hits(input logic [RUN_W-1:0] cur,
                                    input logic [RUN_W-1:0] lim);
    return ({1'b0, cur} + (RUN_W+1)'(1)) >= {1'b0, lim};
  endfunction
endpackage

// File: rtl/sag_phase_det.sv
module sag_phase_det
  import sag_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld,
  input  logic [SW-1:0]       sample,
  input  logic [SW-1:0]       thr,
  input  logic [RUN_W-1:0]    lim,
  input  logic                off,
  output logic                low_evt,
  output logic                clr_evt,
  output logic                sag
);
  // Magnitude of a two's-complement sample as an unsigned SW-bit value.
  function automatic logic [SW-1:0] magnitude(input logic [SW-1:0] s);
    return s[SW-1] ? (~s + SW'(1)) : s;
  endfunction

  logic [RUN_W-1:0] run_q;
  logic             below;

  assign below   = magnitude(sample) < thr;
  assign low_evt = vld && below && !off;
  assign clr_evt = off || (vld && !below);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      sag   <= 1'b0;
    end else if (clr_evt) begin
      run_q <= '0;
      sag   <= 1'b0;
    end else if (low_evt) begin
      run_q <= run_step(run_q, lim);
      sag   <= run_hits(run_q, lim);
    end
  end
endmodule

// File: rtl/sag_irq_route.sv
module sag_irq_route #(
  parameter int NPH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] sag,
  input  logic           irq_en,
  input  logic           pulse_in,
  output logic           irq,
  output logic           pulse_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_en && (|sag);
  end

  assign pulse_out = irq_en ? irq : pulse_in;
endmodule

// File: rtl/sag_monitor.sv
module sag_monitor
  import sag_pkg::*;
#(
  parameter int NPH = 2,
  parameter int SW  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPH-1:0]      smp_vld,
  input  logic [NPH*SW-1:0]   smp,
  input  logic [SW-1:0]       mag_thr,
  input  logic [RUN_W-1:0]    run_len,
  input  logic [NPH-1:0]      phase_off,
  input  logic                irq_en,
  input  logic                pulse_in,
  output logic [NPH-1:0]      sag,
  output logic                irq,
  output logic                pulse_out
);
  logic [RUN_W-1:0] lim;
  logic [NPH-1:0]   low_evt;
  logic [NPH-1:0]   clr_evt;

  assign lim = eff_limit(run_len);

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    sag_phase_det #(.SW(SW)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (smp_vld[p]),
      .sample  (smp[p*SW +: SW]),
      .thr     (mag_thr),
      .lim     (lim),
      .off     (phase_off[p]),
      .low_evt (low_evt[p]),
      .clr_evt (clr_evt[p]),
      .sag     (sag[p])
    );
  end

  sag_irq_route #(.NPH(NPH)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .sag       (sag),
    .irq_en    (irq_en),
    .pulse_in  (pulse_in),
    .irq       (irq),
    .pulse_out (pulse_out)
  );
endmodule

// File: rtl/sag_monitor_chk.sv
module sag_monitor_chk #(
  parameter int NPH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NPH-1:0] smp_vld,
  input logic [NPH-1:0] phase_off,
  input logic [7:0]     run_len,
  input logic           irq_en,
  input logic [NPH-1:0] low_evt,
  input logic [NPH-1:0] clr_evt,
  input logic [NPH-1:0] sag,
  input logic           irq
);
  for (genvar p = 0; p < NPH; p++) begin : g_chk
    // R3
    a_r3_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt[p] && !phase_off[p]) |=> !sag[p]);
    // R7
    a_r7_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      phase_off[p] |=> !sag[p]);
    // R2
    a_r2_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sag[p]) |-> $past(low_evt[p]));
    // R6
    a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (low_evt[p] && run_len == 8'd0) |=> sag[p]);
    // R4
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld[p] && !phase_off[p]) |=> $stable(sag[p]));
  end

  // R8
  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (|sag)) |=> irq);
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

bind sag_monitor sag_monitor_chk #(.NPH(NPH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .phase_off (phase_off),
  .run_len   (run_len),
  .irq_en    (irq_en),
  .low_evt   (low_evt),
  .clr_evt   (clr_evt),
  .sag       (sag),
  .irq       (irq)
);

// File: tb/sim_sag_monitor.sv
`timescale 1ns/1ps
module sim_sag_monitor;
  localparam int NPH = 2;
  localparam int SW  = 16;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [NPH-1:0]    smp_vld = '0;
  logic [NPH*SW-1:0] smp = '0;
  logic [SW-1:0]     mag_thr = 16'd1000;
  logic [7:0]        run_len = 8'd80;
  logic [NPH-1:0]    phase_off = '0;
  logic              irq_en = 0;
  logic              pulse_in = 0;
  logic [NPH-1:0]    sag;
  logic              irq;
  logic              pulse_out;

  int checks = 0;
  int failures = 0;
  string cur_req = "R10";
  bit done = 0;

  always #5 clk = ~clk;

  sag_monitor #(.NPH(NPH), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .mag_thr(mag_thr), .run_len(run_len), .phase_off(phase_off),
    .irq_en(irq_en), .pulse_in(pulse_in),
    .sag(sag), .irq(irq), .pulse_out(pulse_out)
  );

  // Behavioural reference model
  int m_run[NPH];
  bit m_sag[NPH];
  bit m_irq;

  always @(posedge clk) begin
    bit any;
    int lim;
    int s;
    int a;
    any = 0;
    for (int p = 0; p < NPH; p++) any |= m_sag[p];
    if (!rst_n) begin
      for (int p = 0; p < NPH; p++) begin m_run[p] = 0; m_sag[p] = 0; end
      m_irq = 0;
    end else begin
      m_irq = irq_en && any;
      lim = (run_len == 0) ? 1 : int'(run_len);
      for (int p = 0; p < NPH; p++) begin
        s = int'($signed(smp[p*SW +: SW]));
        a = (s < 0) ? -s : s;
        if (phase_off[p]) begin
          m_run[p] = 0; m_sag[p] = 0;
        end else if (smp_vld[p]) begin
          if (a < int'(mag_thr)) begin
            m_run[p] = (m_run[p] + 1 > lim) ? lim : m_run[p] + 1;
            m_sag[p] = (m_run[p] >= lim);
          end else begin
            m_run[p] = 0; m_sag[p] = 0;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit exp_po;
    if (!done) begin
      for (int p = 0; p < NPH; p++)
        chk(sag[p] === m_sag[p], $sformatf("sag[%0d]", p), int'(sag[p]), int'(m_sag[p]));
      chk(irq === m_irq, "irq", int'(irq), int'(m_irq));
      exp_po = irq_en ? m_irq : pulse_in;
      chk(pulse_out === exp_po, "pulse_out", int'(pulse_out), int'(exp_po));
    end
  end

  task automatic step(input logic [NPH-1:0] v, input int a, input int b);
    @(posedge clk); #1;
    smp_vld = v;
    smp[0 +: SW]  = a[SW-1:0];
    smp[SW +: SW] = b[SW-1:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 0, 0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: reset state, with low samples presented during reset
    cur_req = "R10";
    step(2'b11, 1, 1); step(2'b11, 1, 1); step(2'b11, 1, 1);
    @(posedge clk); #1; rst_n = 1;
    idle(2);

    // R2: run of five low samples of both signs on phase A
    cur_req = "R2"; run_len = 8'd5;
    step(2'b01, 10, 0); step(2'b01, -20, 0); step(2'b01, 30, 0);
    step(2'b01, -40, 0); step(2'b01, 0, 0); idle(3);

    // R1: threshold boundary on phase B
    cur_req = "R1"; run_len = 8'd1;
    step(2'b10, 0, 999); idle(1);
    step(2'b10, 0, 1000); idle(1);
    step(2'b10, 0, -999); idle(1);
    step(2'b10, 0, -1000); idle(1);
    step(2'b10, 0, -32768); idle(1);
    step(2'b10, 0, 32767); idle(1);

    // R3: run interrupted by a high sample, then a full new run
    cur_req = "R3"; run_len = 8'd4;
    step(2'b01, 1, 0); step(2'b01, 1, 0); step(2'b01, 1, 0);
    step(2'b01, 5000, 0);
    step(2'b01, 1, 0); step(2'b01, 1, 0); step(2'b01, 1, 0);
    step(2'b01, 1, 0); idle(2); step(2'b01, -1200, 0); idle(2);

    // R4: gaps between low samples do not break or advance the run
    cur_req = "R4"; run_len = 8'd3;
    step(2'b10, 0, 5); idle(4); step(2'b10, 0, 5); idle(7);
    step(2'b10, 0, 5); idle(5); step(2'b10, 0, 2000); idle(3);

    // R5: saturation over a long run at the largest length
    cur_req = "R5"; run_len = 8'd255;
    for (int i = 0; i < 300; i++) step(2'b10, 0, -7);
    step(2'b10, 0, 4000); run_len = 8'd3;
    step(2'b10, 0, 7); step(2'b10, 0, 7); step(2'b10, 0, 7); idle(2);

    // R6: zero length acts as one
    cur_req = "R6"; run_len = 8'd0;
    step(2'b11, 3, -3); idle(1); step(2'b11, 1500, 1500); idle(1);
    step(2'b01, 3, 0); idle(2); step(2'b01, 1500, 0); idle(1);

    // R7: per-phase disable
    cur_req = "R7"; run_len = 8'd2;
    phase_off = 2'b10;
    for (int i = 0; i < 5; i++) step(2'b11, 2, 2);
    phase_off = 2'b01; step(2'b11, 2, 2); step(2'b11, 2, 2);
    phase_off = 2'b00; step(2'b11, 2, 2); step(2'b11, 2, 2); idle(2);
    phase_off = 2'b11; idle(2); phase_off = 2'b00; idle(1);

    // R8 / R9: interrupt enabled, pulse pin routing
    cur_req = "R8"; irq_en = 1; run_len = 8'd2;
    step(2'b01, 1, 0); step(2'b01, 1, 0); idle(3);
    step(2'b01, 3000, 0); idle(3);
    cur_req = "R9"; pulse_in = 1;
    step(2'b10, 0, 1); step(2'b10, 0, 1); idle(2);
    irq_en = 0; idle(2); pulse_in = 0; idle(1); pulse_in = 1; idle(1);
    irq_en = 1; idle(2); step(2'b10, 0, 9999); idle(3);

    // Mixed pseudo-random traffic across all features
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int ra;
      int rb;
      ra = $urandom_range(0, 2400) - 1200;
      rb = $urandom_range(0, 2400) - 1200;
      if (i % 200 == 0) run_len = 8'($urandom_range(0, 6));
      if (i % 150 == 0) phase_off = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
      if (i % 97 == 0) irq_en = ~irq_en;
      pulse_in = 1'($urandom_range(0, 1));
      step(2'($urandom_range(0, 3)), ra, rb);
    end
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule